// File: doc/BRIEF.md
# Lane Predication Condition Stack

This block holds the per-lane write enables of a 32-lane SIMD vector unit that runs structured conditionals by predication. No branch is taken. Every instruction of every arm is issued, and only lanes whose enable bit is set may commit a result. The sequencer sends one opcode per cycle together with a 32-bit vector of per-lane compare results. The block answers with the lane enable mask that applies to the following instructions.

There are two kinds of frame on a hardware stack, and each frame stores the mask that was live when it opened. A conditional frame opens a chain that can hold any number of else-if arms and one else arm. It also records the set of lanes that some arm of the chain has already claimed. A block frame exists only to bound a run of and-narrow operations. Closing either kind of frame restores the mask it saved. A misuse such as overflow, underflow or closing the wrong kind of frame changes no state and raises an error flag that stays set until reset.

Top module: `lane_pred_stack`

## Requirements
- R1: After reset the stack is empty, all 32 lanes are enabled (mask 0xFFFFFFFF), and the error flag is 0.
- R2: Opcode 1 (open-if) pushes a conditional frame. The new mask is the current mask ANDed with the compare vector, so a nested if only ever enables lanes its parent enabled.
- R3: Opcode 2 (else-if) sets the mask to the lanes that were enabled when the chain opened, match the compare vector, and were claimed by no earlier arm of the same chain.
- R4: Opcode 3 (else) sets the mask to exactly the lanes that were enabled when the chain opened and were claimed by no earlier arm of the chain.
- R5: Opcode 4 (end-if) pops the conditional frame and restores the mask that was live before the matching open-if.
- R6: Opcode 6 (narrow) ANDs the current mask with the compare vector inside any open frame, so repeated narrowing only removes lanes.
- R7: Opcode 5 (block-open) pushes a block frame and leaves the mask unchanged. Opcode 7 (block-close) pops it and restores the mask that was live at block-open.
- R8: A push (opcode 1 or 5) while 8 frames are open sets the error flag and changes neither the mask nor the stack.
- R9: Opcodes 2, 3, 4, 6 or 7 with no frame open set the error flag and leave the mask unchanged.
- R10: Opcodes 2, 3 or 4 with a block frame on top, or opcode 7 with a conditional frame on top, set the error flag and change neither the mask nor the stack.
- R11: Once set, the error flag stays 1 until reset, whatever opcodes follow.
- R12: Opcode 0 (no-op) leaves the mask, the stack and the error flag unchanged, whatever the compare vector is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| opCode | input | 3 | Predication opcode, one per cycle (0 = no-op) |
| condVec | input | 32 | Per-lane compare result used by opcodes 1, 2 and 6 |
| laneMask | output | 32 | Registered lane enable mask, updated one cycle after the opcode |
| errFlag | output | 1 | Sticky misuse flag |

## Verification
A corrupted claimed-lanes entry shows up at the next else-if or else of that chain as the wrong lanes enabled. A corrupted saved outer mask shows up only when its frame closes, which can be many cycles after the corruption happened. An off-by-one in the depth counter shows up as a missing or spurious error at the ninth push or at a pop on an empty stack. Restores from nested frames also come out of the wrong slot in that case. The bench therefore compares the mask and the error flag after every opcode against a model kept from the requirements. Deep nesting, chains with several arms, and randomly mixed sequences with misuse make such defects visible within a few operations.

// File: rtl/pred_pkg.sv
package pred_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_IF      = 3'd1,
    OP_ELIF    = 3'd2,
    OP_ELSE    = 3'd3,
    OP_ENDIF   = 3'd4,
    OP_BOPEN   = 3'd5,
    OP_NARROW  = 3'd6,
    OP_BCLOSE  = 3'd7
  } predOp_e;

  typedef enum logic [2:0] {
    MS_KEEP   = 3'd0,
    MS_IF     = 3'd1,
    MS_NARROW = 3'd2,
    MS_ELIF   = 3'd3,
    MS_ELSE   = 3'd4,
    MS_OUTER  = 3'd5
  } maskSel_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic     push;      // write a new frame at wrIdx
    logic     pushIf;    // frame is conditional: claimed = mask & cond
    logic     claimArm;  // OR else-if arm into claimed set of top frame
    logic     claimAll;  // else: claimed set of top frame becomes its outer
    maskSel_e maskSel;   // next-mask source
  } predStrobe_t;

endpackage

// File: rtl/pred_ctrl.sv
module pred_ctrl
  import pred_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [2:0]      opCode,
  output predStrobe_t     strobe,
  output logic [IDXW-1:0] wrIdx,
  output logic [IDXW-1:0] rdIdx,
  output logic [DW-1:0]   depth,
  output logic            errEvent,
  output logic            errFlag
);

  logic [DEPTH-1:0] kindIf;   // 1 = conditional frame, 0 = block frame
  logic             isEmpty, isFull, topIsIf;
  logic             doPush, doPop, pushKind;
  predOp_e          op;

  assign op      = predOp_e'(opCode);
  assign isEmpty = (depth == '0);
  assign isFull  = (depth == DW'(DEPTH));
  assign rdIdx   = isEmpty ? '0 : IDXW'(depth - DW'(1));
  assign wrIdx   = IDXW'(depth);
  assign topIsIf = !isEmpty && kindIf[rdIdx];

  always_comb begin
    strobe   = '{push: 1'b0, pushIf: 1'b0, claimArm: 1'b0,
                 claimAll: 1'b0, maskSel: MS_KEEP};
    errEvent = 1'b0;
    doPush   = 1'b0;
    doPop    = 1'b0;
    pushKind = 1'b0;
    unique case (op)
      OP_IF, OP_BOPEN: begin
        if (isFull) begin
          errEvent = 1'b1;
        end else begin
          doPush        = 1'b1;
          pushKind      = (op == OP_IF);
          strobe.push   = 1'b1;
          strobe.pushIf = (op == OP_IF);
          strobe.maskSel = (op == OP_IF) ? MS_IF : MS_KEEP;
        end
      end
      OP_ELIF: begin
        if (!topIsIf) errEvent = 1'b1;
        else begin
          strobe.claimArm = 1'b1;
          strobe.maskSel  = MS_ELIF;
        end
      end
      OP_ELSE: begin
        if (!topIsIf) errEvent = 1'b1;
        else begin
          strobe.claimAll = 1'b1;
          strobe.maskSel  = MS_ELSE;
        end
      end
      OP_ENDIF: begin
        if (!topIsIf) errEvent = 1'b1;
        else begin
          doPop          = 1'b1;
          strobe.maskSel = MS_OUTER;
        end
      end
      OP_BCLOSE: begin
        if (isEmpty || topIsIf) errEvent = 1'b1;
        else begin
          doPop          = 1'b1;
          strobe.maskSel = MS_OUTER;
        end
      end
      OP_NARROW: begin
        if (isEmpty) errEvent = 1'b1;
        else strobe.maskSel = MS_NARROW;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depth   <= '0;
      errFlag <= 1'b0;
    end else begin
      if (doPush)     depth <= depth + DW'(1);
      else if (doPop) depth <= depth - DW'(1);
      if (errEvent)   errFlag <= 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_kind
    always_ff @(posedge clk) begin
      if (!rstN)                                kindIf[i] <= 1'b0;
      else if (doPush && wrIdx == IDXW'(i))     kindIf[i] <= pushKind;
    end
  end

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
  assert_depth_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    depth <= DW'(DEPTH));
  assert_err_holds_depth_R10: assert property (@(posedge clk) disable iff (!rstN)
    errEvent |=> depth == $past(depth));
  assert_err_raises_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    errEvent |=> errFlag);

endmodule

// File: rtl/pred_datapath.sv
module pred_datapath
  import pred_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] condVec,
  input  predStrobe_t      strobe,
  input  logic [IDXW-1:0]  wrIdx,
  input  logic [IDXW-1:0]  rdIdx,
  output logic [LANES-1:0] laneMask
);

  logic [LANES-1:0] outerStk [DEPTH];
  logic [LANES-1:0] claimStk [DEPTH];
  logic [LANES-1:0] topOuter, topClaim, freeLanes, elifArm, nextMask, pushClaim;

  assign topOuter  = outerStk[rdIdx];
  assign topClaim  = claimStk[rdIdx];
  assign freeLanes = topOuter & ~topClaim;
  assign elifArm   = freeLanes & condVec;
  assign pushClaim = strobe.pushIf ? (laneMask & condVec) : laneMask;

  always_comb begin
    unique case (strobe.maskSel)
      MS_IF, MS_NARROW: nextMask = laneMask & condVec;
      MS_ELIF:          nextMask = elifArm;
      MS_ELSE:          nextMask = freeLanes;
      MS_OUTER:         nextMask = topOuter;
      default:          nextMask = laneMask;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) laneMask <= '1;
    else       laneMask <= nextMask;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_frame
    logic wrNew, wrTop;
    assign wrNew = strobe.push && (wrIdx == IDXW'(i));
    assign wrTop = (strobe.claimArm || strobe.claimAll) && (rdIdx == IDXW'(i));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        outerStk[i] <= '0;
        claimStk[i] <= '0;
      end else if (wrNew) begin
        outerStk[i] <= laneMask;
        claimStk[i] <= pushClaim;
      end else if (wrTop) begin
        claimStk[i] <= strobe.claimAll ? topOuter : (topClaim | elifArm);
      end
    end
  end

  assert_narrow_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.maskSel == MS_NARROW |=> (laneMask & ~$past(laneMask)) == '0);
  assert_else_disjoint_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.maskSel == MS_ELSE |=> (laneMask & $past(topClaim)) == '0);
  assert_elif_fresh_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.maskSel == MS_ELIF |=> (laneMask & ($past(topClaim) | ~$past(topOuter))) == '0);

endmodule

// File: rtl/lane_pred_stack.sv
module lane_pred_stack
  import pred_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       opCode,
  input  logic [LANES-1:0] condVec,
  output logic [LANES-1:0] laneMask,
  output logic             errFlag
);

  predStrobe_t     strobe;
  logic [IDXW-1:0] wrIdx, rdIdx;
  logic [DW-1:0]   depth;
  logic            errEvent;

  pred_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .opCode(opCode), .strobe(strobe),
    .wrIdx(wrIdx), .rdIdx(rdIdx), .depth(depth),
    .errEvent(errEvent), .errFlag(errFlag)
  );

  pred_datapath #(.LANES(LANES), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .condVec(condVec), .strobe(strobe),
    .wrIdx(wrIdx), .rdIdx(rdIdx), .laneMask(laneMask)
  );

  assert_empty_all_on_R1: assert property (@(posedge clk) disable iff (!rstN)
    depth == '0 |-> laneMask == '1);
  assert_err_keeps_mask_R9: assert property (@(posedge clk) disable iff (!rstN)
    errEvent |=> laneMask == $past(laneMask));
  assert_nop_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    opCode == 3'd0 |=> laneMask == $past(laneMask) && depth == $past(depth));

endmodule

// File: tb/tb_lane_pred_stack.sv
module tb_lane_pred_stack;
  localparam int LANES = 32;
  localparam int DEPTH = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [2:0]       opCode = 3'd0;
  logic [LANES-1:0] condVec = '0;
  logic [LANES-1:0] laneMask;
  logic             errFlag;

  lane_pred_stack #(.LANES(LANES), .DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .opCode(opCode), .condVec(condVec),
    .laneMask(laneMask), .errFlag(errFlag)
  );

  always #2 clk = ~clk;  // 250 MHz

  int nTests = 0, nFail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { logic [LANES-1:0] mask; logic err; string tag; int due; } exp_t;
  exp_t expQ[$];

  // Reference state
  logic [LANES-1:0] mOuter [DEPTH];
  logic [LANES-1:0] mClaim [DEPTH];
  logic             mIsIf  [DEPTH];
  int               mDepth;
  logic [LANES-1:0] mMask;
  logic             mErr;

  task automatic modelReset();
    mDepth = 0; mMask = '1; mErr = 1'b0;
  endtask

  task automatic modelStep(input logic [2:0] op, input logic [LANES-1:0] c);
    int t;
    t = mDepth - 1;
    case (op)
      3'd1, 3'd5: begin
        if (mDepth == DEPTH) mErr = 1'b1;
        else begin
          mOuter[mDepth] = mMask;
          mIsIf[mDepth]  = (op == 3'd1);
          if (op == 3'd1) mMask = mMask & c;
          mClaim[mDepth] = mMask;
          mDepth++;
        end
      end
      3'd2: if (mDepth == 0 || !mIsIf[t]) mErr = 1'b1;
            else begin
              mMask = c & mOuter[t] & ~mClaim[t];
              mClaim[t] = mClaim[t] | mMask;
            end
      3'd3: if (mDepth == 0 || !mIsIf[t]) mErr = 1'b1;
            else begin
              mMask = mOuter[t] & ~mClaim[t];
              mClaim[t] = mOuter[t];
            end
      3'd4: if (mDepth == 0 || !mIsIf[t]) mErr = 1'b1;
            else begin mMask = mOuter[t]; mDepth--; end
      3'd7: if (mDepth == 0 || mIsIf[t]) mErr = 1'b1;
            else begin mMask = mOuter[t]; mDepth--; end
      3'd6: if (mDepth == 0) mErr = 1'b1; else mMask = mMask & c;
      default: ;
    endcase
  endtask

  task automatic check(input logic [LANES-1:0] m, input logic e,
                       input logic [LANES-1:0] em, input logic ee, input string tag);
    nTests++;
    if (m !== em || e !== ee) begin
      nFail++;
      $display("FAIL %s: mask=%h err=%b expected mask=%h err=%b", tag, m, e, em, ee);
    end
  endtask

  // Monitor: pop due expectations away from the active edge
  initial forever begin
    @(negedge clk);
    while (expQ.size() > 0 && expQ[0].due <= cyc) begin
      exp_t x;
      x = expQ.pop_front();
      check(laneMask, errFlag, x.mask, x.err, x.tag);
    end
  end

  // Driver
  task automatic doOp(input logic [2:0] op, input logic [LANES-1:0] c, input string tag);
    exp_t x;
    @(posedge clk); #1;
    opCode = op; condVec = c;
    modelStep(op, c);
    x.mask = mMask; x.err = mErr; x.tag = tag; x.due = cyc + 1;
    expQ.push_back(x);
  endtask

  task automatic settle();
    @(posedge clk); #1;
    opCode = 3'd0; condVec = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic doReset();
    settle();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    modelReset();
    @(negedge clk);
    check(laneMask, errFlag, '1, 1'b0, "R1 reset state");
  endtask

  initial begin
    #400000;
    nFail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    modelReset();
    doReset();

    // Chain with several arms
    doOp(3'd1, 32'h0000FFFF, "R2 open-if");
    doOp(3'd2, 32'h00FF00FF, "R3 else-if first");
    doOp(3'd2, 32'hF0F0F0F0, "R3 else-if second");
    doOp(3'd3, 32'h0,        "R4 else");
    doOp(3'd4, 32'h0,        "R5 end-if");

    // Nested if with narrowing
    doOp(3'd1, 32'hAAAAAAAA, "R2 outer if");
    doOp(3'd1, 32'h0000FFFF, "R2 nested if");
    doOp(3'd6, 32'h0000FF00, "R6 narrow in arm");
    doOp(3'd6, 32'h0F0F0F0F, "R6 narrow again");
    doOp(3'd3, 32'h0,        "R4 nested else");
    doOp(3'd4, 32'h0,        "R5 inner end-if");
    doOp(3'd4, 32'h0,        "R5 outer end-if");

    // Block with narrowing
    doOp(3'd5, 32'h0,        "R7 block-open");
    doOp(3'd6, 32'h12345678, "R6 narrow in block");
    doOp(3'd6, 32'hFFFF0000, "R6 narrow in block again");
    doOp(3'd7, 32'h0,        "R7 block-close");
    doOp(3'd0, 32'h00000000, "R12 no-op");
    doOp(3'd1, 32'h00F00000, "R12 setup");
    doOp(3'd0, 32'hFFFFFFFF, "R12 no-op with cond");
    doOp(3'd2, 32'hFFFFFFFF, "R12 chain intact after no-op");
    doOp(3'd4, 32'h0,        "R12 close");

    // Kind mismatch
    doOp(3'd5, 32'h0,        "R10 setup block");
    doOp(3'd6, 32'h0000FFFF, "R10 narrow");
    doOp(3'd4, 32'h0,        "R10 end-if on block");
    doOp(3'd2, 32'hFFFFFFFF, "R10 else-if on block");
    doOp(3'd7, 32'h0,        "R10 block still closes");
    doOp(3'd0, 32'h0,        "R11 flag stays");
    doOp(3'd1, 32'h0000000F, "R11 flag stays on valid op");
    doOp(3'd7, 32'h0,        "R10 block-close on if");
    doOp(3'd4, 32'h0,        "R10 if still closes");
    doReset();

    // Overflow
    for (int i = 0; i < DEPTH; i++) doOp(3'd1, ~(32'h1 << i), "R8 fill");
    doOp(3'd1, 32'h0,        "R8 push on full");
    doOp(3'd5, 32'h0,        "R8 block push on full");
    doOp(3'd4, 32'h0,        "R8 top frame intact");
    doReset();

    // Underflow
    doOp(3'd4, 32'h0,        "R9 end-if on empty");
    doReset();
    doOp(3'd6, 32'h0000FFFF, "R9 narrow on empty");
    doReset();
    doOp(3'd7, 32'h0,        "R9 block-close on empty");
    doOp(3'd3, 32'h0,        "R9 else on empty");
    doReset();

    // Mixed pseudo-random sequences
    for (int r = 0; r < 6; r++) begin
      for (int k = 0; k < 80; k++) begin
        logic [2:0] op;
        op = 3'($urandom_range(0, 7));
        doOp(op, $urandom(), "RND R2 R3 R4 R5 R6 R7");
      end
      doReset();
    end

    settle();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule